// File: doc/BRIEF.md
# Interleaved PCM Bus Multiplexer

This block merges the 2.048 Mbit/s serial streams of up to four framer channels onto a single faster PCM bus. All channels share one input bit strobe and one input frame marker. Each channel's bits are captured into a two-bank frame buffer. A sequencer reads the completed frames back out at four times the input rate when all four channels share the bus. When only two channels share it, the sequencer reads at twice the input rate.

A four-bit control register chooses the mode. It sets whether the bus runs, whether channels take turns per byte or per whole frame, whether the block is the bus master, and whether the bus carries two or four channels. A master starts its bus frame on an input frame boundary and marks bit 0 of every bus frame with a one-clock sync pulse. A slave drives no sync. It starts and aligns its bus frame on an incoming sync pulse.

Top module: `pcm_ilv_bus`

## Requirements
- R1: After reset the control register reads 0, and `bus_data`, `bus_stb` and `bus_sync_out` are 0.
- R2: A write on `cfg_we` loads `cfg_wdata[3:0]`: bit 0 enables the bus, bit 1 selects frame interleave (0 = byte), bit 2 selects the master role, bit 3 selects four channels (0 = two channels, channels 0 and 1). `cfg_rdata` returns those four bits, and bits 7:4 always read 0.
- R3: Every fourth clock carries an input bit (`in_stb`). A frame is 256 bits per channel, and bit 0 is marked by `in_fsync` together with `in_stb`. The bus frame that starts at the boundary of input frame N carries input frame N-1.
- R4: In four-channel mode `bus_stb` is high on every clock of a running bus frame, which gives 1024 bus bits per 1024-clock frame.
- R5: In two-channel mode `bus_stb` is high only on even positions of the 1024-clock bus frame, which gives 512 bits. Only channels 0 and 1 appear on the bus.
- R6: In byte interleave, bus bit k carries channel (k/8) mod C, where C is the channel count. It carries timeslot k/(8·C) and bit k mod 8 of that timeslot, MSB first. The channel bit index is timeslot·8 + bit.
- R7: In frame interleave, bus bit k carries channel k/256, channel bit k mod 256.
- R8: A master starts its bus frame on the first input frame boundary after a control write. It raises `bus_sync_out` for one clock at bus position 0 of every 1024-clock frame.
- R9: A slave never drives `bus_sync_out`. Its outputs stay 0 until `bus_sync_in` arrives. A `bus_sync_in` pulse sets bus position 0 in that clock.
- R10: With the enable bit clear, `bus_data`, `bus_stb` and `bus_sync_out` stay 0.
- R11: A control write stops the running bus frame. The outputs stay 0 until the bus frame restarts under R8 or R9.
- R12: All bus outputs are registered and appear one clock after the bus position that produces them. `bus_data` is 0 whenever `bus_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock (four times the input bit rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register read value |
| in_stb | input | 1 | Input bit strobe, one clock in four |
| in_fsync | input | 1 | Input frame marker, valid with `in_stb` |
| in_data | input | 4 | One serial input bit per channel |
| bus_sync_in | input | 1 | Bus frame sync from the master (slave role) |
| bus_data | output | 1 | Interleaved bus data |
| bus_stb | output | 1 | Bus bit valid |
| bus_sync_out | output | 1 | Bus frame sync pulse (master role) |

## Verification
The input frame boundary and bus position 0 fall in the same clock. In that clock the buffer switches its write bank and writes bit 0 of the new frame, while the sequencer reads bit 0 of the old frame. The bench provokes this in every running frame by tying the bus start to the input marker, in both the master and the slave roles. It judges the result by comparing each bus bit against a pattern computed from channel, frame number and bit index. A control write can also land while a bus frame is running. The bench places these writes mid-frame and expects silent outputs until the next restart.

// File: rtl/pcm_ilv_pkg.sv
package pcm_ilv_pkg;

    localparam int REG_W = 8;

    // control fields, bit 0 = enable
    typedef struct packed {
        logic four;    // four-channel bus
        logic master;  // drives bus sync
        logic frame;   // frame interleave
        logic en;      // bus enable
    } ilv_cfg_t;

    localparam int CFG_W = $bits(ilv_cfg_t);

endpackage

// File: rtl/pcm_ilv_cfg.sv
module pcm_ilv_cfg
    import pcm_ilv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output ilv_cfg_t         cfg
);

    ilv_cfg_t c_d, c_q;
    logic [REG_W-CFG_W-1:0] unused_hi;

    assign unused_hi = cfg_wdata[REG_W-1:CFG_W];

    always_comb begin
        c_d = c_q;
        if (cfg_we) c_d = ilv_cfg_t'(cfg_wdata[CFG_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cfg       = c_q;
    assign cfg_rdata = {{(REG_W-CFG_W){1'b0}}, c_q};

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == REG_W'($past(cfg_wdata[CFG_W-1:0]))));

endmodule

// File: rtl/pcm_ilv_chbuf.sv
module pcm_ilv_chbuf #(
    parameter  int FRAME_BITS = 256,
    localparam int IDX_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_stb,
    input  logic             in_fsync,
    input  logic             in_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    typedef struct packed {
        logic [1:0][FRAME_BITS-1:0] mem;
        logic [IDX_W-1:0]           wr_idx;
        logic                       bank;
    } buf_st_t;

    buf_st_t s_d, s_q;
    logic    frame_start;
    logic    wr_bank;
    logic [IDX_W-1:0] wr_pos;

    always_comb begin
        s_d         = s_q;
        frame_start = in_stb & in_fsync;
        wr_bank     = frame_start ? ~s_q.bank : s_q.bank;
        wr_pos      = frame_start ? '0 : s_q.wr_idx;
        if (in_stb) begin
            s_d.mem[wr_bank][wr_pos] = in_bit;
            s_d.wr_idx               = wr_pos + IDX_W'(1);
            s_d.bank                 = wr_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read side always sees the bank that is not being filled
    assign rd_bit = s_q.mem[~wr_bank][rd_idx];

    assert_bank_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && in_fsync) |=> (s_q.bank != $past(s_q.bank)));

    assert_idx_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && in_fsync) |=> (s_q.wr_idx == IDX_W'(1)));

    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stb |=> ($stable(s_q.wr_idx) && $stable(s_q.bank)));

endmodule

// File: rtl/pcm_ilv_seq.sv
module pcm_ilv_seq
    import pcm_ilv_pkg::*;
#(
    parameter  int CHANNELS   = 4,
    parameter  int FRAME_BITS = 256,
    parameter  int SLOT_BITS  = 8,
    localparam int BUS_CYC    = FRAME_BITS * CHANNELS,
    localparam int POS_W      = $clog2(BUS_CYC),
    localparam int IDX_W      = $clog2(FRAME_BITS),
    localparam int BIT_W      = $clog2(SLOT_BITS),
    localparam int CH_W       = $clog2(CHANNELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ilv_cfg_t            cfg,
    input  logic                cfg_we,
    input  logic                in_stb,
    input  logic                in_fsync,
    input  logic                bus_sync_in,
    input  logic [CHANNELS-1:0] rd_bits,
    output logic [IDX_W-1:0]    rd_idx,
    output logic                bus_data,
    output logic                bus_stb,
    output logic                bus_sync_out
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             run;
        logic             data;
        logic             stb;
        logic             sync;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic             start, live;
    logic [POS_W-1:0] cur, k, kb, slot;
    logic [CH_W-1:0]  ch;
    logic [IDX_W-1:0] idx;

    always_comb begin
        s_d   = s_q;
        start = cfg.en & (cfg.master ? (in_stb & in_fsync & ~s_q.run) : bus_sync_in);
        live  = cfg.en & (s_q.run | start);
        cur   = start ? '0 : s_q.pos;
        k     = cfg.four ? cur : (cur >> 1);
        kb    = k >> BIT_W;
        slot  = '0;
        if (cfg.frame) begin
            ch  = CH_W'(k >> IDX_W);
            idx = k[IDX_W-1:0];
        end else begin
            if (cfg.four) begin
                ch   = kb[CH_W-1:0];
                slot = kb >> CH_W;
            end else begin
                ch   = CH_W'(kb[CH_W-2:0]);
                slot = kb >> (CH_W-1);
            end
            idx = IDX_W'({slot, k[BIT_W-1:0]});
        end
        s_d.pos  = live ? cur + POS_W'(1) : '0;
        s_d.run  = live & ~cfg_we;
        s_d.stb  = live & (cfg.four | ~cur[0]);
        s_d.sync = live & cfg.master & (cur == '0);
        s_d.data = live & (cfg.four | ~cur[0]) & rd_bits[ch];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_idx       = idx;
    assign bus_data     = s_q.data;
    assign bus_stb      = s_q.stb;
    assign bus_sync_out = s_q.sync;

    assert_sync_on_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sync_out |-> bus_stb);

    assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.master |=> !bus_sync_out);

    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (!bus_stb && !bus_data && !bus_sync_out));

    assert_data_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_stb |-> !bus_data);

    assert_two_ch_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !cfg.four && cfg.master && !cfg_we && !$past(cfg_we)) |=> !bus_stb);

    assert_write_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !(in_stb && in_fsync) && !bus_sync_in) |=> ##1 !bus_stb || $past(in_stb && in_fsync) || $past(bus_sync_in));

endmodule

// File: rtl/pcm_ilv_bus.sv
module pcm_ilv_bus
    import pcm_ilv_pkg::*;
#(
    parameter  int CHANNELS   = 4,
    parameter  int SLOTS      = 32,
    parameter  int SLOT_BITS  = 8,
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int IDX_W      = $clog2(FRAME_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic                in_stb,
    input  logic                in_fsync,
    input  logic [CHANNELS-1:0] in_data,
    input  logic                bus_sync_in,
    output logic                bus_data,
    output logic                bus_stb,
    output logic                bus_sync_out
);

    ilv_cfg_t            cfg;
    logic [CHANNELS-1:0] rd_bits;
    logic [IDX_W-1:0]    rd_idx;

    pcm_ilv_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg       (cfg)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        pcm_ilv_chbuf #(.FRAME_BITS(FRAME_BITS)) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_stb   (in_stb),
            .in_fsync (in_fsync),
            .in_bit   (in_data[c]),
            .rd_idx   (rd_idx),
            .rd_bit   (rd_bits[c])
        );
    end

    pcm_ilv_seq #(
        .CHANNELS   (CHANNELS),
        .FRAME_BITS (FRAME_BITS),
        .SLOT_BITS  (SLOT_BITS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg          (cfg),
        .cfg_we       (cfg_we),
        .in_stb       (in_stb),
        .in_fsync     (in_fsync),
        .bus_sync_in  (bus_sync_in),
        .rd_bits      (rd_bits),
        .rd_idx       (rd_idx),
        .bus_data     (bus_data),
        .bus_stb      (bus_stb),
        .bus_sync_out (bus_sync_out)
    );

endmodule

// File: tb/pcm_ilv_bus_test.sv
`timescale 1ns/1ps
module pcm_ilv_bus_test;

    localparam int NCH    = 4;
    localparam int FB     = 256;
    localparam int BUSCYC = 1024;
    localparam int CFG_AT = 100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       in_stb, in_fsync, bus_sync_in;
    logic [NCH-1:0] in_data;
    logic       bus_data, bus_stb, bus_sync_out;

    always #2.5 clk = ~clk;

    pcm_ilv_bus uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .in_stb(in_stb), .in_fsync(in_fsync),
        .in_data(in_data), .bus_sync_in(bus_sync_in), .bus_data(bus_data),
        .bus_stb(bus_stb), .bus_sync_out(bus_sync_out)
    );

    int checks = 0, errors = 0;
    int T = 0;
    int cfg_tick = -1;
    int run_from = -1;
    bit started = 0, req = 0, slave_go = 0;
    logic [7:0] req_val = '0;
    logic [3:0] mcfg = '0;
    int e_data, e_stb, e_sync, e_idle;
    string m_data, m_stb, m_sync, m_idle;

    function automatic bit pat(int c, int f, int i);
        int h;
        h = c * 1103 + f * 97 + i * 13 + ((i * i) >> 3);
        return h[2];
    endfunction

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic drive(int t);
        bit stb;
        stb = (t % 4) == 0;
        in_stb   = stb;
        in_fsync = (t % BUSCYC) == 0;
        for (int c = 0; c < NCH; c++)
            in_data[c] = stb ? pat(c, t / BUSCYC, (t % BUSCYC) / 4) : t[1];
        if (req && (t % BUSCYC) == CFG_AT) begin
            cfg_we    = 1'b1;
            cfg_wdata = req_val;
            req       = 0;
            cfg_tick  = t;
            mcfg      = req_val[3:0];
            slave_go  = 0;
            run_from  = (req_val[0] && req_val[2]) ? (t / BUSCYC + 1) * BUSCYC : -1;
        end else begin
            cfg_we = 1'b0;
        end
        bus_sync_in = slave_go && mcfg[0] && !mcfg[2] && ((t % BUSCYC) == 0);
        if (bus_sync_in && run_from < 0) run_from = t;
    endtask

    // sample outputs produced by the clock edge of tick t
    task automatic monitor(int t);
        int p, k, nch, ch, idx;
        bit es, ed, ey;
        if (cfg_tick < 0 || t <= cfg_tick) return;
        if (run_from < 0 || t < run_from) begin
            if (bus_data || bus_stb || bus_sync_out) begin
                if (e_idle == 0) m_idle = $sformatf("tick %0d out=%0b%0b%0b", t, bus_data, bus_stb, bus_sync_out);
                e_idle++;
            end
            return;
        end
        p   = t % BUSCYC;
        nch = mcfg[3] ? 4 : 2;
        es  = mcfg[3] ? 1'b1 : ((p % 2) == 0);
        k   = mcfg[3] ? p : p / 2;
        if (mcfg[1]) begin
            ch  = k / FB;
            idx = k % FB;
        end else begin
            ch  = (k / 8) % nch;
            idx = (k / (8 * nch)) * 8 + k % 8;
        end
        ed = es ? pat(ch, t / BUSCYC - 1, idx) : 1'b0;
        ey = mcfg[2] && (p == 0);
        if (bus_stb !== es) begin
            if (e_stb == 0) m_stb = $sformatf("tick %0d stb=%0b exp %0b", t, bus_stb, es);
            e_stb++;
        end
        if (bus_data !== ed) begin
            if (e_data == 0) m_data = $sformatf("tick %0d ch%0d bit%0d data=%0b exp %0b", t, ch, idx, bus_data, ed);
            e_data++;
        end
        if (bus_sync_out !== ey) begin
            if (e_sync == 0) m_sync = $sformatf("tick %0d sync=%0b exp %0b", t, bus_sync_out, ey);
            e_sync++;
        end
    endtask

    initial begin : loop
        wait (started);
        forever begin
            @(negedge clk);
            monitor(T);
            T++;
            drive(T);
        end
    end

    task automatic run_seg(logic [7:0] val, bit slave, string t_data, string t_stb,
                           string t_sync, string t_idle);
        int base;
        e_data = 0; e_stb = 0; e_sync = 0; e_idle = 0;
        m_data = ""; m_stb = ""; m_sync = ""; m_idle = "";
        req_val = val;
        req = 1;
        wait (req == 0);
        base = cfg_tick;
        if (slave) begin
            wait (T >= base + 1500);
            slave_go = 1;
            base = base + 1500;
        end
        wait (T >= base + BUSCYC + 2100);
        check(cfg_rdata == {4'h0, val[3:0]}, "R2", $sformatf("readback of %0h", val),
              cfg_rdata, {4'h0, val[3:0]});
        if (e_data != 0) $display("  first data mismatch: %s", m_data);
        check(e_data == 0, t_data, "bus data mismatches", e_data, 0);
        if (e_stb != 0) $display("  first strobe mismatch: %s", m_stb);
        check(e_stb == 0, t_stb, "bus strobe mismatches", e_stb, 0);
        if (e_sync != 0) $display("  first sync mismatch: %s", m_sync);
        check(e_sync == 0, t_sync, "bus sync mismatches", e_sync, 0);
        if (e_idle != 0) $display("  first idle activity: %s", m_idle);
        check(e_idle == 0, t_idle, "activity while stopped", e_idle, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; in_stb = 1'b0;
        in_fsync = 1'b0; in_data = '0; bus_sync_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        T = 0;
        drive(0);
        started = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 8'h00, "R1", "cfg after reset", cfg_rdata, 0);
        check(bus_stb == 1'b0, "R1", "bus_stb after reset", bus_stb, 0);
        check(bus_data == 1'b0, "R1", "bus_data after reset", bus_data, 0);
        check(bus_sync_out == 1'b0, "R1", "bus_sync_out after reset", bus_sync_out, 0);

        // master, four channels, frame interleave; upper bits written as ones
        run_seg(8'hFF, 0, "R3 R7", "R4", "R8", "R11");
        // master, four channels, byte interleave
        run_seg(8'h0D, 0, "R6 R12", "R4", "R8", "R11");
        // master, two channels, byte interleave
        run_seg(8'h05, 0, "R5 R6", "R5", "R8", "R11");
        // master, two channels, frame interleave
        run_seg(8'h07, 0, "R5 R7", "R5", "R8", "R11");
        // slave, four channels, byte interleave
        run_seg(8'h09, 1, "R9 R6", "R9 R4", "R9", "R9");
        // slave, two channels, frame interleave
        run_seg(8'h03, 1, "R9 R7", "R9 R5", "R9", "R9");
        // disabled with other fields set
        run_seg(8'h0E, 0, "R10", "R10", "R10", "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule